// File: doc/BRIEF.md
# Ethernet MAC Enable and Local Reset Sequencer

This block holds the control word that switches a fast Ethernet MAC on and off and that starts a reset confined to the MAC. Software writes the word through a simple write strobe and reads it back at any time. A single-cycle pulse from the bus fabric reports a fatal bus error, and that pulse also takes the MAC offline.

The two directions shut down differently. Receive is gated off in the cycle after the disable. Transmit is allowed to keep running while a frame is on the wire. The block then asks the transmitter to close that frame with a deliberately corrupted CRC, and it waits for the transmitter to acknowledge. Only after that does it issue a one-cycle strobe that clears the DMA, descriptor and FIFO pointers. No descriptor write-back takes place for the aborted frame.

A write with the reset bit set works differently. It drops everything abruptly and drives a register-file reset for a fixed number of cycles. During that time the reset bit reads back as 1, and all writes are dropped. The bit then clears itself.

Top module: `mac_ctrl_seq`

## Requirements
- R1: A write with bit 1 (enable) set and bit 0 (reset) clear drives `mac_en` and `tx_run` high after the next clock edge, and `rd_data` bit 1 then reads 1.
- R2: Clearing the enable bit while no frame is in flight (`tx_frame` low) drops `mac_en` and `tx_run` after the same edge, and `ptr_rst` is high for exactly that one cycle.
- R3: Clearing the enable bit while `tx_frame` is high drops `mac_en` at once. `abort_req` and `tx_run` stay high until `tx_abort_ack` is sampled. In the cycle after the acknowledge, `abort_req` and `tx_run` are low and `ptr_rst` pulses for one cycle.
- R4: A write with bit 0 set clears `mac_en`, cancels any pending abort without a `ptr_rst` pulse, and holds `busy` and `regs_rst` high for RST_CYCLES cycles (8 by default). After that, both return low by themselves.
- R5: While `busy` is high, `rd_data` bit 0 reads 1, and writes have no effect on `mac_en`.
- R6: A `bus_err` pulse clears `mac_en`. The transmit shutdown then follows R2 or R3, depending on `tx_frame`.
- R7: `rd_data` bits above bit 1 always read 0, and writing ones to them changes no output.
- R8: A write with both bit 0 and bit 1 set starts the reset sequence and leaves `mac_en` low.
- R9: While `abort_req` is high, a write without bit 0 set is ignored.
- R10: After the synchronous `rst`, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | DATA_W | Control word write value |
| rd_data | output | DATA_W | Control word read value |
| bus_err | input | 1 | Fatal bus error pulse |
| tx_frame | input | 1 | Transmitter has a frame in flight |
| tx_abort_ack | input | 1 | Transmitter has sent the bad-CRC frame end |
| mac_en | output | 1 | MAC enabled (receive gate) |
| tx_run | output | 1 | Transmit allowed |
| abort_req | output | 1 | Request to end the current frame with a bad CRC |
| ptr_rst | output | 1 | One-cycle DMA/descriptor/FIFO pointer reset |
| regs_rst | output | 1 | MAC register-file reset, held during the sequence |
| busy | output | 1 | Reset sequence running |

## Verification
The bench targets disabling in the middle of a frame. A design that also gated transmit at once would drop `tx_run` early. A design that pulsed the pointers before the acknowledge would show `ptr_rst` while `abort_req` is still high. The bench also checks that the reset sequence is exactly eight cycles long, since an off-by-one counter moves the falling edge of `busy`. It checks that a reset write cancels a pending abort with no stray pointer strobe, and that a combined reset-and-enable write leaves the MAC off. It also writes during the sequence and during a pending abort, so any leak of those writes would show up on `mac_en`.

// File: rtl/mac_ctrl_pkg.sv
package mac_ctrl_pkg;
  localparam int CTRL_RST_BIT = 0;
  localparam int CTRL_EN_BIT  = 1;
endpackage

// File: rtl/mcs_rst_seq.sv
module mcs_rst_seq #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt    <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt    <= CW'(CYCLES - 1);
    end else if (busy_q) begin
      if (cnt == '0) busy_q <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign busy = busy_q;

  int unsigned run_len;
  always_ff @(posedge clk) begin
    if (rst)         run_len <= 0;
    else if (busy_q) run_len <= run_len + 1;
    else             run_len <= 0;
  end

  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (run_len == CYCLES)); // R4
endmodule

// File: rtl/mcs_tx_drain.sv
module mcs_tx_drain (
  input  logic clk,
  input  logic rst,
  input  logic cancel,
  input  logic disable_evt,
  input  logic tx_frame,
  input  logic tx_abort_ack,
  output logic abort_req,
  output logic ptr_rst
);
  logic abort_q, ptr_q;

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      abort_q <= 1'b0;
      ptr_q   <= 1'b0;
    end else if (disable_evt) begin
      abort_q <= tx_frame;
      ptr_q   <= !tx_frame;
    end else if (abort_q && tx_abort_ack) begin
      abort_q <= 1'b0;
      ptr_q   <= 1'b1;
    end else begin
      ptr_q   <= 1'b0;
    end
  end

  assign abort_req = abort_q;
  assign ptr_rst   = ptr_q;

  AST_PTR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ptr_q |=> !ptr_q); // R2
  AST_NO_PTR_WHILE_ABORT: assert property (@(posedge clk) disable iff (rst)
    abort_q |-> !ptr_q); // R3
endmodule

// File: rtl/mac_ctrl_seq.sv
module mac_ctrl_seq
  import mac_ctrl_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              bus_err,
  input  logic              tx_frame,
  input  logic              tx_abort_ack,
  output logic              mac_en,
  output logic              tx_run,
  output logic              abort_req,
  output logic              ptr_rst,
  output logic              regs_rst,
  output logic              busy
);
  logic en_q;
  logic seq_busy;
  logic start_rst;
  logic wr_ctl;
  logic disable_evt;

  assign start_rst   = wr_en && !seq_busy && wr_data[CTRL_RST_BIT];
  assign wr_ctl      = wr_en && !seq_busy && !abort_req && !wr_data[CTRL_RST_BIT];
  assign disable_evt = en_q && !start_rst &&
                       (bus_err || (wr_ctl && !wr_data[CTRL_EN_BIT]));

  always_ff @(posedge clk) begin
    if (rst)            en_q <= 1'b0;
    else if (start_rst) en_q <= 1'b0;
    else if (bus_err)   en_q <= 1'b0;
    else if (wr_ctl)    en_q <= wr_data[CTRL_EN_BIT];
  end

  mcs_rst_seq #(.CYCLES(RST_CYCLES)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start_rst),
    .busy  (seq_busy)
  );

  mcs_tx_drain u_drain (
    .clk          (clk),
    .rst          (rst),
    .cancel       (start_rst),
    .disable_evt  (disable_evt),
    .tx_frame     (tx_frame),
    .tx_abort_ack (tx_abort_ack),
    .abort_req    (abort_req),
    .ptr_rst      (ptr_rst)
  );

  always_comb begin
    rd_data               = '0;
    rd_data[CTRL_EN_BIT]  = en_q;
    rd_data[CTRL_RST_BIT] = seq_busy;
  end

  assign mac_en   = en_q;
  assign tx_run   = en_q || abort_req;
  assign regs_rst = seq_busy;
  assign busy     = seq_busy;

  AST_RST_WINS: assert property (@(posedge clk) disable iff (rst)
    start_rst |=> (!mac_en && busy)); // R8
  AST_BERR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    bus_err |=> !mac_en); // R6
  AST_BUSY_NO_EN: assert property (@(posedge clk) disable iff (rst)
    busy |-> !mac_en); // R5
  AST_ABORT_HOLDS_TX: assert property (@(posedge clk) disable iff (rst)
    abort_req |-> tx_run); // R3
  AST_PENDING_LOCK: assert property (@(posedge clk) disable iff (rst)
    (abort_req && !tx_abort_ack && !(wr_en && wr_data[CTRL_RST_BIT]))
      |=> (abort_req && !mac_en)); // R9
endmodule

// File: tb/sim_mac_ctrl_seq.sv
module sim_mac_ctrl_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        bus_err = 1'b0;
  logic        tx_frame = 1'b0;
  logic        tx_abort_ack = 1'b0;
  logic        mac_en, tx_run, abort_req, ptr_rst, regs_rst, busy;

  int checks = 0;
  int errors = 0;
  logic [37:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #4 clk = ~clk;

  mac_ctrl_seq u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .bus_err(bus_err), .tx_frame(tx_frame), .tx_abort_ack(tx_abort_ack),
    .mac_en(mac_en), .tx_run(tx_run), .abort_req(abort_req), .ptr_rst(ptr_rst),
    .regs_rst(regs_rst), .busy(busy)
  );

  // monitor: compares outputs against queued expectations
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [37:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {mac_en, tx_run, abort_req, ptr_rst, regs_rst, busy, rd_data};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  // driver: one clock cycle of stimulus, then the expected outputs
  task automatic cyc(input logic w, input logic [31:0] d, input logic be,
                     input logic fr, input logic ack, input string t,
                     input logic en, input logic txr, input logic ab,
                     input logic pr, input logic bz);
    wr_en = w; wr_data = d; bus_err = be; tx_frame = fr; tx_abort_ack = ack;
    @(posedge clk);
    #1;
    wr_en = 1'b0; wr_data = '0; bus_err = 1'b0; tx_abort_ack = 1'b0;
    exp_q.push_back({en, txr, ab, pr, bz, bz, 30'd0, en, bz});
    tag_q.push_back(t);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cyc(0, 0, 0, 0, 0, "R10 reset state", 0, 0, 0, 0, 0);
    rst = 1'b0;
    cyc(0, 0, 0, 0, 0, "R10 idle", 0, 0, 0, 0, 0);
    cyc(1, 32'h2, 0, 0, 0, "R1 enable", 1, 1, 0, 0, 0);
    cyc(1, 32'hFFFF_FFFE, 0, 0, 0, "R7 reserved ignored", 1, 1, 0, 0, 0);
    cyc(1, 32'h0, 0, 0, 0, "R2 disable idle", 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, "R2 strobe one cycle", 0, 0, 0, 0, 0);
    cyc(1, 32'h2, 0, 0, 0, "R1 re-enable", 1, 1, 0, 0, 0);
    cyc(1, 32'h0, 0, 1, 0, "R3 disable mid frame", 0, 1, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, "R3 abort held", 0, 1, 1, 0, 0);
    cyc(1, 32'h2, 0, 1, 0, "R9 write ignored", 0, 1, 1, 0, 0);
    cyc(0, 0, 0, 1, 1, "R3 ack ends abort", 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, "R3 strobe one cycle", 0, 0, 0, 0, 0);
    cyc(1, 32'h2, 0, 0, 0, "R1 enable again", 1, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, "R6 bus error idle", 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, "R6 strobe one cycle", 0, 0, 0, 0, 0);
    cyc(1, 32'h2, 0, 0, 0, "R1 enable before error", 1, 1, 0, 0, 0);
    cyc(0, 0, 1, 1, 0, "R6 bus error mid frame", 0, 1, 1, 0, 0);
    cyc(1, 32'h1, 0, 1, 0, "R4 reset cancels abort", 0, 0, 0, 0, 1);
    tx_frame = 1'b0;
    for (int i = 1; i < 8; i++) begin
      if (i == 3) cyc(1, 32'h2, 0, 0, 0, "R5 write during busy", 0, 0, 0, 0, 1);
      else        cyc(0, 0, 0, 0, 0, "R4 busy window", 0, 0, 0, 0, 1);
    end
    cyc(0, 0, 0, 0, 0, "R4 self clear", 0, 0, 0, 0, 0);
    cyc(1, 32'h3, 0, 0, 0, "R8 reset beats enable", 0, 0, 0, 0, 1);
    for (int i = 1; i < 8; i++) cyc(0, 0, 0, 0, 0, "R4 busy window 2", 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, "R4 self clear 2", 0, 0, 0, 0, 0);
    cyc(1, 32'h2, 0, 0, 0, "R1 enable after reset", 1, 1, 0, 0, 0);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule